// File: doc/BRIEF.md
# Dual bi-quinary decade counter

The block holds two independent four-bit counter units. Each unit is made of a toggle stage (divide by two) and a modulo-five stage (divide by five). Each stage has its own clock input and advances on that clock's falling edge. A static order input per unit picks how the two stages are chained inside the unit. In decimal order the toggle stage output clocks the modulo-five stage, and the four bits read out 0 to 9. In bi-quinary order the modulo-five stage's top bit clocks the toggle stage. The toggle bit then becomes the most significant output bit and is a square wave at one tenth of the input rate, high for exactly half of the period.

All four state bits of each unit are visible at the output at all times, so every sub-multiple of the input rate can be used. Each unit has an asynchronous active-high clear. Feeding the top output bit of one unit, in decimal order, into the toggle clock of the other gives a two-digit decimal counter of period 100. The ports carry no data stream, so there is no valid/ready handshake. All pins are plain control and status pins.

Top module: `bq_decade_pair`

## Requirements
- R1: While `clr[u]` is 1, all four bits of unit u read 0 at once, with no clock edge needed, and falling edges on that unit's clock inputs have no effect.
- R2: A stage changes state only on a falling edge (1 to 0) of its clock. A rising edge leaves the outputs unchanged.
- R3: With `biq[u]`=0 (decimal order), unit u outputs `{quin[2:0], tog}` on `cnt[4u+3:4u]`. Each falling edge of `tog_clk[u]` advances the value by one through 0..9, and 9 wraps to 0.
- R4: With `biq[u]`=0, edges on `quin_clk[u]` have no effect on unit u.
- R5: With `biq[u]`=1 (bi-quinary order), unit u outputs `{tog, quin[2:0]}`. Each falling edge of `quin_clk[u]` steps the value through the sequence 0,1,2,3,4,8,9,10,11,12 and then back to 0.
- R6: With `biq[u]`=1, bit 3 of unit u is high for exactly 5 consecutive `quin_clk[u]` falls and then low for exactly 5 falls. It flips only on the fall that takes the low three bits from 4 to 0.
- R7: With `biq[u]`=1, edges on `tog_clk[u]` have no effect on unit u.
- R8: Clocking or clearing one unit leaves the other unit's outputs unchanged.
- R9: With both units in decimal order and `cnt[3]` driving `tog_clk[1]`, N falls of `tog_clk[0]` from a clear give `cnt` = BCD digits of N mod 100 (tens in `cnt[7:4]`). The pair therefore returns to 0 after exactly 100 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tog_clk | input | UNITS (2) | Per-unit clock of the toggle stage (used in decimal order) |
| quin_clk | input | UNITS (2) | Per-unit clock of the modulo-five stage (used in bi-quinary order) |
| clr | input | UNITS (2) | Per-unit asynchronous clear, active high |
| biq | input | UNITS (2) | Per-unit chaining order: 0 decimal, 1 bi-quinary; change only while clear is high |
| cnt | output | 4*UNITS (8) | Unit u state on bits 4u+3..4u |

## Verification
The hardest situation to reach is the cascade wrap: unit 1 has no clock of its own in that test. It advances only when the ripple of unit 0 passes 9 to 0 and drops its top bit. Seeing unit 1 return to zero therefore takes a full hundred input falls. The stimulus routes `cnt[3]` into unit 1's toggle clock and applies 120 falls, comparing both digits after every edge and checking for all zeros at fall 100. The bi-quinary duty cycle is checked over twenty falls by counting high samples and measuring the longest high run. Clears and order changes are applied with clock pulses on the clock inputs while clear is held, which shows that those edges are ignored.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int QUIN_MOD = 5;
  localparam int QUIN_W   = $clog2(QUIN_MOD);
  localparam int UNIT_W   = QUIN_W + 1;
endpackage

// File: rtl/bq_tog_stage.sv
module bq_tog_stage (
  input  logic clk_f,
  input  logic clr,
  output logic q
);
  always_ff @(negedge clk_f or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= ~q;
  end
endmodule

// File: rtl/bq_quin_stage.sv
module bq_quin_stage #(
  parameter int MOD = 5,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk_f,
  input  logic         clr,
  output logic [W-1:0] st
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(negedge clk_f or posedge clr) begin
    if (clr)             st <= '0;
    else if (st == LAST) st <= '0;
    else                 st <= st + 1'b1;
  end
endmodule

// File: rtl/bq_unit.sv
module bq_unit
  import bq_pkg::*;
(
  input  logic              tog_clk,
  input  logic              quin_clk,
  input  logic              clr,
  input  logic              biq,
  output logic [UNIT_W-1:0] q
);
  logic              tog_q;
  logic [QUIN_W-1:0] quin_q;
  logic              tog_ck;
  logic              quin_ck;

  // chaining order: which stage output clocks the other
  assign tog_ck  = biq ? quin_q[QUIN_W-1] : tog_clk;
  assign quin_ck = biq ? quin_clk         : tog_q;

  bq_tog_stage u_tog (
    .clk_f(tog_ck),
    .clr  (clr),
    .q    (tog_q)
  );

  bq_quin_stage #(.MOD(QUIN_MOD)) u_quin (
    .clk_f(quin_ck),
    .clr  (clr),
    .st   (quin_q)
  );

  assign q = biq ? {tog_q, quin_q} : {quin_q, tog_q};
endmodule

// File: rtl/bq_decade_pair.sv
module bq_decade_pair
  import bq_pkg::*;
#(
  parameter int UNITS = 2
) (
  input  logic [UNITS-1:0]        tog_clk,
  input  logic [UNITS-1:0]        quin_clk,
  input  logic [UNITS-1:0]        clr,
  input  logic [UNITS-1:0]        biq,
  output logic [UNITS*UNIT_W-1:0] cnt
);
  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    bq_unit u_unit (
      .tog_clk (tog_clk[g]),
      .quin_clk(quin_clk[g]),
      .clr     (clr[g]),
      .biq     (biq[g]),
      .q       (cnt[g*UNIT_W +: UNIT_W])
    );
  end
endmodule

// File: rtl/bq_decade_chk.sv
module bq_decade_chk #(
  parameter int UNITS = 2
) (
  input logic [UNITS-1:0]   tog_clk,
  input logic [UNITS-1:0]   quin_clk,
  input logic [UNITS-1:0]   clr,
  input logic [UNITS-1:0]   biq,
  input logic [UNITS*4-1:0] cnt
);
  for (genvar g = 0; g < UNITS; g++) begin : g_chk
    logic [3:0] q;
    assign q = cnt[g*4 +: 4];

    // R1
    always @(posedge tog_clk[g]) begin
      if (clr[g]) clear_hold_chk: assert (q == 4'd0);
    end

    // R1
    always @(posedge quin_clk[g]) begin
      if (clr[g]) clear_hold_q_chk: assert (q == 4'd0);
    end

    // R3
    bcd_step_chk: assert property (@(negedge tog_clk[g]) disable iff (clr[g] || biq[g])
      1'b1 |=> (q == (($past(q) == 4'd9) ? 4'd0 : $past(q) + 4'd1)));

    // R3
    bcd_range_chk: assert property (@(posedge tog_clk[g]) disable iff (clr[g] || biq[g])
      q <= 4'd9);

    // R5
    biq_step_chk: assert property (@(negedge quin_clk[g]) disable iff (clr[g] || !biq[g])
      1'b1 |=> (q[2:0] == (($past(q[2:0]) == 3'd4) ? 3'd0 : $past(q[2:0]) + 3'd1)));

    // R6
    biq_half_chk: assert property (@(negedge quin_clk[g]) disable iff (clr[g] || !biq[g])
      (q[2:0] == 3'd4) |=> (q[3] != $past(q[3])));

    // R6
    biq_hold_chk: assert property (@(negedge quin_clk[g]) disable iff (clr[g] || !biq[g])
      (q[2:0] != 3'd4) |=> $stable(q[3]));
  end
endmodule

bind bq_decade_pair bq_decade_chk #(.UNITS(UNITS)) u_chk (
  .tog_clk (tog_clk),
  .quin_clk(quin_clk),
  .clr     (clr),
  .biq     (biq),
  .cnt     (cnt)
);

// File: tb/tb_bq_decade_pair.sv
`timescale 1ns/1ps
module tb_bq_decade_pair;
  logic       clk = 1'b0;
  logic [1:0] tclk = 2'b00;
  logic [1:0] qclk = 2'b00;
  logic [1:0] clr  = 2'b11;
  logic [1:0] biq  = 2'b00;
  logic       casc = 1'b0;
  logic [1:0] tog_clk;
  logic [7:0] cnt;

  assign tog_clk = {casc ? cnt[3] : tclk[1], tclk[0]};

  bq_decade_pair dut (
    .tog_clk (tog_clk),
    .quin_clk(qclk),
    .clr     (clr),
    .biq     (biq),
    .cnt     (cnt)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  int nvec = 0, nfail = 0;
  int m_pos [2] = '{0, 0};
  bit m_biq [2] = '{0, 0};
  bit done = 0;

  function automatic logic [3:0] digit(int u);
    if (m_biq[u]) return 4'((m_pos[u] < 5) ? m_pos[u] : m_pos[u] + 3);
    return 4'(m_pos[u]);
  endfunction

  task automatic push(string tag);
    item_t it;
    it.exp = {digit(1), digit(0)};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, sampled mid-cycle
  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      nvec++;
      if (cnt !== it.exp) begin
        nfail++;
        $display("FAIL %s: cnt=%h expected %h", it.tag, cnt, it.exp);
      end
    end
  end

  // one clock pulse on a unit's toggle (quin=0) or modulo-five (quin=1) input
  task automatic pulse(int u, bit quin, string tag);
    @(posedge clk);
    if (quin) qclk[u] = 1'b1; else tclk[u] = 1'b1;
    push("R2");
    @(posedge clk);
    if (quin) qclk[u] = 1'b0; else tclk[u] = 1'b0;
    if (quin == m_biq[u]) begin
      m_pos[u] = (m_pos[u] + 1) % 10;
      if (u == 0 && casc && m_pos[0] == 0 && !m_biq[1])
        m_pos[1] = (m_pos[1] + 1) % 10;
    end
    push(tag);
  endtask

  // clear the masked units, pulse their clocks under clear, set order
  task automatic do_clear(logic [1:0] mask, logic [1:0] nbiq, bit ncasc);
    @(posedge clk);
    clr = clr | mask;
    for (int u = 0; u < 2; u++) if (mask[u]) m_pos[u] = 0;
    push("R1");
    @(posedge clk);
    biq  = (biq & ~mask) | (nbiq & mask);
    casc = ncasc;
    tclk = tclk | mask;
    qclk = qclk | mask;
    push("R1");
    @(posedge clk);
    tclk = tclk & ~mask;
    qclk = qclk & ~mask;
    push("R1");
    @(posedge clk);
    clr = clr & ~mask;
    for (int u = 0; u < 2; u++) if (mask[u]) m_biq[u] = biq[u];
    push("R1");
  endtask

  initial begin
    #200000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int highs, run, maxrun;
    // reset state
    do_clear(2'b11, 2'b00, 1'b0);

    // R3: decimal count with wrap, R8: other unit independent
    for (int i = 0; i < 12; i++) pulse(0, 1'b0, "R3");
    for (int i = 0; i < 3; i++)  pulse(1, 1'b0, "R8");
    // R4: modulo-five input ignored in decimal order
    for (int i = 0; i < 2; i++)  pulse(0, 1'b1, "R4");
    // R8: clearing unit 0 keeps unit 1
    do_clear(2'b01, 2'b00, 1'b0);
    pulse(0, 1'b0, "R8");

    // R5: bi-quinary sequence
    do_clear(2'b11, 2'b11, 1'b0);
    for (int i = 0; i < 12; i++) pulse(0, 1'b1, "R5");
    // R7: toggle input ignored
    for (int i = 0; i < 2; i++)  pulse(0, 1'b0, "R7");
    for (int i = 0; i < 7; i++)  pulse(1, 1'b1, "R5");

    // R6: duty cycle of bit 3 over two periods
    do_clear(2'b01, 2'b01, 1'b0);
    highs = 0; run = 0; maxrun = 0;
    for (int i = 0; i < 20; i++) begin
      pulse(0, 1'b1, "R6");
      @(negedge clk);
      if (cnt[3]) begin
        highs++; run++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
    chk(highs == 10, "R6 high count", highs, 10);
    chk(maxrun == 5, "R6 high run", maxrun, 5);

    // R9: cascade to divide by 100
    do_clear(2'b11, 2'b00, 1'b1);
    for (int i = 0; i < 100; i++) pulse(0, 1'b0, "R9");
    wait (sb.size() == 0);
    @(negedge clk);
    chk(cnt == 8'h00, "R9 period 100", cnt, 0);
    for (int i = 0; i < 20; i++) pulse(0, 1'b0, "R9");
    wait (sb.size() == 0);
    @(negedge clk);
    chk(cnt == 8'h20, "R9 after 120", cnt, 8'h20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule